// File: doc/BRIEF.md
# DMA Address Map Register File

This block holds a bank of page-mapping entries that turn narrow device-bus DMA addresses into wider physical memory addresses. A processor reaches the entries through a small register port with word and byte writes. Every entry is 22 bits wide and is seen as two 16-bit registers. The even register carries the low part of the entry. The odd register carries the upper six bits.

A DMA engine presents an 18-bit bus address on the translation port. The block splits it into a 5-bit page number and a 13-bit offset. It adds the offset to the selected entry and registers the 22-bit result, which stays readable until the next request. The topmost page never uses the table: it always lands on a fixed I/O page base plus the offset. With mapping turned off, the bus address goes through with zeros above it.

Top module: `dma_map_top`

## Requirements
- R1: After reset every entry reads as zero, `xl_phys` is zero and `xl_ack` is low.
- R2: A read with `reg_addr[1]`=0 returns entry bits 15:1 with bit 0 as zero. A read with `reg_addr[1]`=1 returns entry bits 21:16 in bits 5:0 and zeros in bits 15:6. `reg_addr[0]` has no effect on reads.
- R3: A word write (`reg_wr`=1, `reg_byte`=0) replaces entry bits 15:0 when `reg_addr[1]`=0, or bits 21:16 from `reg_wdata[5:0]` when `reg_addr[1]`=1. The other half of the entry is left unchanged.
- R4: A byte write (`reg_byte`=1) replaces only entry byte `reg_addr[1:0]`, taking its data from `reg_wdata[7:0]`. Lane 2 keeps only 6 bits, and lane 3 leaves the entry unchanged.
- R5: After any write, bit 0 of the stored entry is zero.
- R6: The entry selected by the register port is `reg_addr[6:2]`. A write changes no other entry.
- R7: With `map_en`=1 and a page below 31, `xl_phys` on the cycle after `xl_req` equals (entry[`xl_bus_addr[17:13]`] + `xl_bus_addr[12:0]`) mod 2^22. `xl_ack` is high for that one cycle.
- R8: With `map_en`=1 and page 31, `xl_phys` becomes IO_BASE (default 0x3FE000) plus the offset, whatever entry 31 holds.
- R9: With `map_en`=0, `xl_phys` becomes the 18-bit bus address with zeros in bits 21:18.
- R10: While `xl_req` is low, `xl_phys` holds its last value and `xl_ack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 7 | Register address: entry in 6:2, half in 1, byte lane in 1:0 |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_byte | input | 1 | 1 = byte write, 0 = word write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| map_en | input | 1 | 1 = translate through the table, 0 = pass through |
| xl_req | input | 1 | Translation request |
| xl_bus_addr | input | 18 | Bus address to translate |
| xl_phys | output | 22 | Last translated physical address |
| xl_ack | output | 1 | High on the cycle after a request |

## Verification
The bench writes byte lanes 2 and 3 to an entry that is already full. A design that let lane 3 through, or kept all 8 bits of lane 2, would read back a changed odd half. It gives a word write the odd half, with junk in bits 15:6 of the data, and then rewrites the even half, so a design that clears or widens the other half shows a wrong readback. Translations cover an entry near the top of the physical space, where a design that did not wrap would need a 23rd bit. They also cover page 31 with a nonzero entry 31, where a design that looked up the table would miss the I/O base. Pass-through is tried on page 31 as well, so a design that tested for the last page before `map_en` would return the I/O base.

// File: rtl/dma_map_pkg.sv
// Shared types for the DMA address map block.
// Assumes: the physical address width is 32 bits or less.
package dma_map_pkg;
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_WORD = 2'd1,
        ACC_BYTE = 2'd2
    } acc_e;
endpackage

// File: rtl/dma_map_regfile.sv
// Map entry storage with the processor-side register port.
// Each entry is PHYS_AW bits, seen as an even register (low 16 bits)
// and an odd register (upper bits). Bit 0 of an entry is always zero.
// Assumes: 16 < PHYS_AW <= 32, and single-cycle write strobes.
module dma_map_regfile
    import dma_map_pkg::*;
#(
    parameter int PAGES   = 32,
    parameter int PHYS_AW = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  acc_e               acc,
    input  logic [$clog2(PAGES)+1:0] addr,
    input  logic [15:0]        wdata,
    output logic [15:0]        rdata,
    output logic [PHYS_AW-1:0] entry_o [PAGES]
);
    localparam int IDX_W = $clog2(PAGES);
    localparam int HI_W  = PHYS_AW - 16;

    logic [PHYS_AW-1:0] map_q [PAGES];
    logic [IDX_W-1:0]   idx;
    logic               half;
    logic [1:0]         lane;
    logic [31:0]        merged;
    logic [PHYS_AW-1:0] nxt;
    logic [PHYS_AW-1:0] sel;
    logic               unused_hi;

    assign idx  = addr[IDX_W+1:2];
    assign half = addr[1];
    assign lane = addr[1:0];

    // Merge the write data into the addressed entry and clear bit 0.
    always_comb begin
        merged = 32'(map_q[idx]);
        if (acc == ACC_BYTE)
            merged[lane*8 +: 8] = wdata[7:0];
        else
            merged[half*16 +: 16] = wdata;
        nxt = merged[PHYS_AW-1:0] & ~PHYS_AW'(1);
    end

    assign unused_hi = ^merged[31:PHYS_AW];

    // One storage register per entry, written when the port selects it.
    for (genvar g = 0; g < PAGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[g] <= '0;
            else if (acc != ACC_NONE && idx == IDX_W'(g))
                map_q[g] <= nxt;
        end
        assign entry_o[g] = map_q[g];
    end

    // Select the even or odd half of the addressed entry for reading.
    always_comb begin
        sel = map_q[idx];
        if (half)
            rdata = {{(16-HI_W){1'b0}}, sel[PHYS_AW-1:16]};
        else
            rdata = {sel[15:1], 1'b0};
    end

    // R3: a word write to the even half leaves the upper bits alone
    a_r3_word_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WORD && !half) |=>
        map_q[$past(idx)][PHYS_AW-1:16] == $past(map_q[idx][PHYS_AW-1:16]));

    // R4: a byte write to lane 3 leaves the entry unchanged
    a_r4_lane3_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_BYTE && lane == 2'd3) |=> map_q[$past(idx)] == $past(map_q[idx]));

    // R5: a written entry never holds bit 0 set
    a_r5_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_NONE) |=> map_q[$past(idx)][0] == 1'b0);

    // R2: the odd half reads with its unused upper bits at zero
    a_r2_odd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        half |-> rdata[15:HI_W] == '0);
endmodule

// File: rtl/dma_map_xlate.sv
// Translation path: page lookup, offset add, fixed I/O page for the last
// page, pass-through when mapping is off. The result is registered and
// held until the next request.
// Assumes: BUS_AW - OFF_W bits of page number index exactly PAGES entries.
module dma_map_xlate #(
    parameter int                 PAGES   = 32,
    parameter int                 BUS_AW  = 18,
    parameter int                 PHYS_AW = 22,
    parameter int                 OFF_W   = 13,
    parameter logic [PHYS_AW-1:0] IO_BASE = 22'h3FE000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHYS_AW-1:0] entry_i [PAGES],
    input  logic               en,
    input  logic               req,
    input  logic [BUS_AW-1:0]  bus_addr,
    output logic [PHYS_AW-1:0] phys,
    output logic               ack
);
    localparam int PAGE_W = BUS_AW - OFF_W;
    localparam logic [PAGE_W-1:0] LAST_PG = PAGE_W'(PAGES - 1);

    logic [PAGE_W-1:0]  page;
    logic [PHYS_AW-1:0] off_ext;
    logic [PHYS_AW-1:0] base;
    logic [PHYS_AW-1:0] xl_nxt;

    assign page    = bus_addr[BUS_AW-1:OFF_W];
    assign off_ext = PHYS_AW'(bus_addr[OFF_W-1:0]);

    // Choose the page base and form the truncated physical address.
    always_comb begin
        base = (page == LAST_PG) ? IO_BASE : entry_i[page];
        if (en)
            xl_nxt = base + off_ext;
        else
            xl_nxt = PHYS_AW'(bus_addr);
    end

    // Latch the result on a request; acknowledge one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys <= '0;
            ack  <= 1'b0;
        end else begin
            ack <= req;
            if (req)
                phys <= xl_nxt;
        end
    end

    // R8: the last page lands on the fixed I/O base
    a_r8_last_page: assert property (@(posedge clk) disable iff (!rst_n)
        (req && en && page == LAST_PG) |=> phys == IO_BASE + $past(off_ext));

    // R9: pass-through keeps the bus address with zero upper bits
    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !en) |=> phys == PHYS_AW'($past(bus_addr)));

    // R10: no request, no change
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(phys) && !ack));

    // R7: the offset bits of a mapped result follow from entry plus offset
    a_r7_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req && en && page != LAST_PG) |=>
        phys[OFF_W-1:0] == $past(entry_i[page][OFF_W-1:0] + bus_addr[OFF_W-1:0]));
endmodule

// File: rtl/dma_map_top.sv
// DMA address map: register file of page entries plus translation path.
// Assumes: one register access per cycle; reg_wr is a one-cycle strobe.
module dma_map_top
    import dma_map_pkg::*;
#(
    parameter int                 BUS_AW  = 18,
    parameter int                 PHYS_AW = 22,
    parameter int                 OFF_W   = 13,
    parameter logic [PHYS_AW-1:0] IO_BASE = 22'h3FE000,
    localparam int                PAGES   = 2 ** (BUS_AW - OFF_W),
    localparam int                RA_W    = BUS_AW - OFF_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RA_W-1:0]    reg_addr,
    input  logic               reg_wr,
    input  logic               reg_byte,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic               map_en,
    input  logic               xl_req,
    input  logic [BUS_AW-1:0]  xl_bus_addr,
    output logic [PHYS_AW-1:0] xl_phys,
    output logic               xl_ack
);
    acc_e               acc;
    logic [PHYS_AW-1:0] entries [PAGES];

    // Decode the strobe and size into one access kind.
    always_comb begin
        if (!reg_wr)      acc = ACC_NONE;
        else if (reg_byte) acc = ACC_BYTE;
        else              acc = ACC_WORD;
    end

    dma_map_regfile #(.PAGES(PAGES), .PHYS_AW(PHYS_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc(acc), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .entry_o(entries)
    );

    dma_map_xlate #(.PAGES(PAGES), .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW),
                    .OFF_W(OFF_W), .IO_BASE(IO_BASE)) u_xl (
        .clk(clk), .rst_n(rst_n), .entry_i(entries), .en(map_en),
        .req(xl_req), .bus_addr(xl_bus_addr), .phys(xl_phys), .ack(xl_ack)
    );
endmodule

// File: tb/dma_map_top_tb.sv
// Scoreboard bench: translation driver pushes expected addresses,
// a negedge monitor pops them when xl_ack is seen.
module dma_map_top_tb;
    localparam logic [21:0] IOB = 22'h3FE000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_byte = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        map_en = 1'b0, xl_req = 1'b0;
    logic [17:0] xl_bus_addr = '0;
    logic [21:0] xl_phys;
    logic        xl_ack;

    int n_chk = 0, n_fail = 0;
    logic [21:0] mdl [32];
    logic [21:0] q_exp [$];
    string       q_tag [$];

    always #10 clk = ~clk;

    dma_map_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_byte(reg_byte), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .map_en(map_en), .xl_req(xl_req), .xl_bus_addr(xl_bus_addr),
        .xl_phys(xl_phys), .xl_ack(xl_ack)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d, logic b);
        logic [31:0] v;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_byte = b; reg_wr = 1'b1;
        v = 32'(mdl[a[6:2]]);
        if (b) v[a[1:0]*8 +: 8] = d[7:0];
        else   v[a[1]*16 +: 16] = d;
        mdl[a[6:2]] = v[21:0] & ~22'd1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, string tag);
        logic [15:0] e;
        @(negedge clk);
        reg_addr = a;
        #1;
        e = a[1] ? {10'd0, mdl[a[6:2]][21:16]} : {mdl[a[6:2]][15:1], 1'b0};
        check(tag, 32'(reg_rdata), 32'(e));
    endtask

    task automatic xl(logic [17:0] ba, logic en, string tag);
        logic [21:0] e;
        if (!en)                 e = 22'(ba);
        else if (ba[17:13] == 5'd31) e = IOB + 22'(ba[12:0]);
        else                     e = mdl[ba[17:13]] + 22'(ba[12:0]);
        @(negedge clk);
        map_en = en; xl_bus_addr = ba; xl_req = 1'b1;
        q_exp.push_back(e); q_tag.push_back(tag);
        @(negedge clk);
        xl_req = 1'b0;
    endtask

    // Monitor: compare each acknowledged translation with the queue.
    always @(negedge clk) begin
        if (rst_n && xl_ack) begin
            if (q_exp.size() == 0) check("xl spurious ack", 32'd1, 32'd0);
            else check(q_tag.pop_front(), 32'(xl_phys), 32'(q_exp.pop_front()));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [21:0] held;
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 phys after reset", 32'(xl_phys), 32'd0);
        check("R1 ack after reset", 32'(xl_ack), 32'd0);
        rd(7'd0, "R1 entry0 even"); rd(7'd126, "R1 entry31 odd");
        // R5 and R2: bit 0 cleared, even readback
        wr(7'h14, 16'h1235, 1'b0); rd(7'h14, "R5 bit0 cleared");
        // R2: odd half keeps 6 bits, upper read zero, addr bit 0 ignored
        wr(7'h16, 16'hFFFF, 1'b0); rd(7'h16, "R2 odd half"); rd(7'h17, "R2 odd addr0 ignored");
        // R3: rewrite even half, odd kept
        wr(7'h14, 16'hABCD, 1'b0); rd(7'h16, "R3 odd kept"); rd(7'h14, "R3 even new");
        // R4: byte lanes on entry 9
        wr(7'h26, 16'h003F, 1'b0);
        wr(7'h24, 16'h5A11, 1'b1); rd(7'h24, "R4 lane0");
        wr(7'h25, 16'h00C3, 1'b1); rd(7'h24, "R4 lane1");
        wr(7'h26, 16'h0081, 1'b1); rd(7'h26, "R4 lane2 six bits");
        wr(7'h27, 16'h00FF, 1'b1); rd(7'h26, "R4 lane3 no effect"); rd(7'h24, "R4 lane3 even kept");
        // R6: entry index decode
        wr(7'h00, 16'h2222, 1'b0); wr(7'h7C, 16'h7776, 1'b0); wr(7'h7E, 16'h0015, 1'b0);
        rd(7'h00, "R6 entry0"); rd(7'h7C, "R6 entry31"); rd(7'h14, "R6 entry5 untouched");
        // R7: mapped translation, including wraparound
        wr(7'h0C, 16'hFFF0, 1'b0); wr(7'h0E, 16'h003F, 1'b0);
        xl({5'd5, 13'h0123}, 1'b1, "R7 page5");
        xl({5'd9, 13'h1FFF}, 1'b1, "R7 page9");
        xl({5'd3, 13'h0020}, 1'b1, "R7 wrap");
        xl({5'd2, 13'h0FFF}, 1'b1, "R7 zero entry");
        // R8: last page ignores entry 31
        xl({5'd31, 13'h0000}, 1'b1, "R8 last page base");
        xl({5'd31, 13'h1ABC}, 1'b1, "R8 last page offset");
        // R9: pass-through, page 31 included
        xl({5'd31, 13'h0042}, 1'b0, "R9 passthru page31");
        xl({5'd5, 13'h0123}, 1'b0, "R9 passthru page5");
        // R10: hold with no request
        @(negedge clk);
        held = xl_phys;
        xl_bus_addr = 18'h3FFFF; map_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 phys held", 32'(xl_phys), 32'(held));
        check("R10 ack low", 32'(xl_ack), 32'd0);
        check("R7 queue drained", 32'(q_exp.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule